// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block looks after an asynchronous DRAM's housekeeping. After reset it holds every strobe inactive for a power-up pause. It then runs a fixed number of initialization cycles, and only after those does it flag the memory as ready for host traffic. From then on an interval timer adds one owed refresh to a small backlog counter at the rate needed to cover every row within the retention window. Each owed refresh is paid off with a CAS-before-RAS cycle. In that cycle the memory's internal row counter supplies the row, so no address is produced here.

The access controller sees a refresh request and answers with a grant once its own traffic is idle. While the grant is held, the block drives RAS, both byte CAS strobes, WE and OE itself. It pays off the whole backlog in one back-to-back burst and then drops the request. When the backlog is full, an urgent flag tells the controller to close its open row and grant the bus at once. The initialization cycles are CAS-before-RAS cycles as well, and they need no grant. All durations are given in nanoseconds and converted to clock cycles from the clock frequency parameter.

Top module: `dram_housekeeper`

## Requirements
- R1: During reset, ras_n, lcas_n, ucas_n, we_n and oe_n are 1, and init_done, ref_req, ref_urgent and strobe_own are 0.
- R2: No strobe goes low during the first PAUSE cycles after reset is released, where PAUSE = ceil(PAUSE_NS·CLK_HZ/1e9).
- R3: Exactly INIT_CYCLES (default 8) RAS low pulses occur before init_done rises, with ref_gnt held 0 throughout. init_done then stays 1.
- R4: Every refresh is CAS-before-RAS. Both CAS strobes are low for at least CSR cycles before RAS falls, and they stay low for as long as RAS is low.
- R5: Each RAS low pulse lasts exactly TRAS = ceil(TRAS_NS·CLK_HZ/1e9) cycles.
- R6: After RAS rises, at least TRP = ceil(TRP_NS·CLK_HZ/1e9) cycles pass before CAS falls again.
- R7: we_n and oe_n are 1 at all times, so the DRAM neither writes nor drives its data pins.
- R8: An owed refresh is added every INTERVAL = floor(WINDOW_NS·CLK_HZ/(ROWS·1e9)) cycles. The first one comes INTERVAL cycles after init_done rises. ref_req is 1 whenever the backlog is nonzero.
- R9: After initialization, no RAS pulse starts while ref_gnt is 0.
- R10: Once granted, the block runs exactly as many refresh cycles as are owed, back to back, and then lowers ref_req.
- R11: ref_urgent is 1 exactly when the backlog holds PEND_MAX (default 8) owed refreshes.
- R12: An interval that expires while the backlog is full adds nothing. A later grant then produces exactly PEND_MAX refresh cycles.
- R13: strobe_own is 1 in every cycle in which RAS or either CAS strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Controller grants the bus for refresh |
| init_done | output | 1 | Power-up sequence complete; host access allowed |
| ref_req | output | 1 | Refresh owed or in progress |
| ref_urgent | output | 1 | Backlog full; grant needed at once |
| strobe_own | output | 1 | Block is driving the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Low-byte column strobe, active low |
| ucas_n | output | 1 | High-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |

## Verification
The first RAS fall is due PAUSE+CSR+1 cycles after reset release; the bench only requires it to come no earlier than PAUSE. ref_req is due exactly INTERVAL edges after init_done rises, so the bench counts falling-edge samples between the two. Strobe widths are measured by run-length counters updated on every falling edge, and each width is compared when the strobe releases. In each grant round the bench waits a whole number of intervals plus a mid-interval offset, so no tick falls near the sample point. It then compares the RAS pulse count in the burst against the expected backlog.

// File: rtl/hk_pkg.sv
package hk_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CSET  = 2'd1,
    SQ_RASLO = 2'd2,
    SQ_PRECH = 2'd3
  } seq_state_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(longint ns, longint hz);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  // refresh spacing, rounded down so the window is always met
  function automatic int interval_cyc(longint window_ns, longint rows, longint hz);
    longint c;
    c = (window_ns * hz) / (rows * 64'd1_000_000_000);
    return (c < 2) ? 2 : int'(c);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/hk_interval_timer.sv
module hk_interval_timer #(
  parameter int PERIOD = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = $clog2(PERIOD);

  logic [W-1:0] cnt_q;

  assign tick = en && (cnt_q == W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hk_backlog.sv
module hk_backlog #(
  parameter int MAX = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         inc,
  input  logic                         dec,
  output logic [$clog2(MAX+1)-1:0]     count,
  output logic                         full
);
  localparam int W = $clog2(MAX + 1);

  logic [W-1:0] cnt_q;

  assign count = cnt_q;
  assign full  = (cnt_q == W'(MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc && !dec && !full) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec && !inc && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hk_cbr_seq.sv
module hk_cbr_seq
  import hk_pkg::*;
#(
  parameter int CSR_CYC  = 2,
  parameter int TRAS_CYC = 7,
  parameter int TRP_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int MAXC = max3(CSR_CYC, TRAS_CYC, TRP_CYC);
  localparam int W    = $clog2(MAXC + 1);

  seq_state_t   st_q;
  logic [W-1:0] cnt_q;
  logic         last;

  assign last  = (cnt_q == '0);
  assign idle  = (st_q == SQ_IDLE);
  assign done  = (st_q == SQ_PRECH) && last;
  assign ras_n = (st_q != SQ_RASLO);
  assign cas_n = !((st_q == SQ_CSET) || (st_q == SQ_RASLO));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start) begin
          st_q  <= SQ_CSET;
          cnt_q <= W'(CSR_CYC - 1);
        end
        SQ_CSET: if (last) begin
          st_q  <= SQ_RASLO;
          cnt_q <= W'(TRAS_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        SQ_RASLO: if (last) begin
          st_q  <= SQ_PRECH;
          cnt_q <= W'(TRP_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: if (last) begin
          st_q <= SQ_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dram_housekeeper.sv
module dram_housekeeper
  import hk_pkg::*;
#(
  parameter longint CLK_HZ      = 125_000_000,
  parameter longint PAUSE_NS    = 200_000,
  parameter longint WINDOW_NS   = 64_000_000,
  parameter longint ROWS        = 4096,
  parameter longint TRAS_NS     = 50,
  parameter longint TRP_NS      = 30,
  parameter longint TCSR_NS     = 10,
  parameter int     INIT_CYCLES = 8,
  parameter int     PEND_MAX    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic init_done,
  output logic ref_req,
  output logic ref_urgent,
  output logic strobe_own,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n,
  output logic we_n,
  output logic oe_n
);
  localparam int PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_HZ);
  localparam int TRAS_CYC  = ns_to_cyc(TRAS_NS, CLK_HZ);
  localparam int TRP_CYC   = ns_to_cyc(TRP_NS, CLK_HZ);
  localparam int CSR_CYC   = ns_to_cyc(TCSR_NS, CLK_HZ);
  localparam int INTERVAL  = interval_cyc(WINDOW_NS, ROWS, CLK_HZ);
  localparam int PW        = $clog2(PAUSE_CYC + 1);
  localparam int IW        = $clog2(INIT_CYCLES + 1);
  localparam int BW        = $clog2(PEND_MAX + 1);

  phase_t        phase_q;
  logic [PW-1:0] pause_q;
  logic [IW-1:0] init_left_q;

  logic          pause_active;
  logic          interval_tick;
  logic          seq_start, seq_idle, seq_done, seq_ras_n, seq_cas_n;
  logic [BW-1:0] backlog;
  logic          backlog_full;
  logic          run_ph;

  assign pause_active = (phase_q == PH_PAUSE);
  assign run_ph       = (phase_q == PH_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_PAUSE;
      pause_q     <= '0;
      init_left_q <= IW'(INIT_CYCLES);
    end else begin
      case (phase_q)
        PH_PAUSE: begin
          if (pause_q == PW'(PAUSE_CYC - 1)) phase_q <= PH_INIT;
          else                                pause_q <= pause_q + 1'b1;
        end
        PH_INIT: if (seq_done) begin
          init_left_q <= init_left_q - 1'b1;
          if (init_left_q == IW'(1)) phase_q <= PH_RUN;
        end
        default: ;
      endcase
    end
  end

  hk_interval_timer #(.PERIOD(INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run_ph),
    .tick  (interval_tick)
  );

  hk_backlog #(.MAX(PEND_MAX)) u_backlog (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (interval_tick),
    .dec   (seq_done && run_ph),
    .count (backlog),
    .full  (backlog_full)
  );

  assign seq_start = seq_idle &&
                     (((phase_q == PH_INIT) && (init_left_q != '0)) ||
                      (run_ph && (backlog != '0) && ref_gnt));

  hk_cbr_seq #(
    .CSR_CYC  (CSR_CYC),
    .TRAS_CYC (TRAS_CYC),
    .TRP_CYC  (TRP_CYC)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (seq_start),
    .idle  (seq_idle),
    .done  (seq_done),
    .ras_n (seq_ras_n),
    .cas_n (seq_cas_n)
  );

  assign init_done  = run_ph;
  assign ref_req    = run_ph && ((backlog != '0) || !seq_idle);
  assign ref_urgent = backlog_full;
  assign strobe_own = !seq_idle;
  assign ras_n      = seq_ras_n;
  assign lcas_n     = seq_cas_n;
  assign ucas_n     = seq_cas_n;
  assign we_n       = 1'b1;
  assign oe_n       = 1'b1;
endmodule

// File: rtl/dram_housekeeper_chk.sv
module dram_housekeeper_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic init_done,
  input logic ref_req,
  input logic ref_urgent,
  input logic strobe_own,
  input logic ras_n,
  input logic lcas_n,
  input logic ucas_n,
  input logic pause_active,
  input logic interval_tick
);
  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!lcas_n && !ucas_n && $past(!lcas_n) && $past(!ucas_n)));

  // R4
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (!lcas_n && !ucas_n));

  // R13
  strobe_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !lcas_n || !ucas_n) |-> strobe_own);

  // R2
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_active |-> (ras_n && lcas_n && ucas_n && !init_done));

  // R9
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && init_done) |-> ref_gnt);

  // R11
  urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ref_req);

  // R8
  tick_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    interval_tick |=> ref_req);
endmodule

bind dram_housekeeper dram_housekeeper_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ref_gnt       (ref_gnt),
  .init_done     (init_done),
  .ref_req       (ref_req),
  .ref_urgent    (ref_urgent),
  .strobe_own    (strobe_own),
  .ras_n         (ras_n),
  .lcas_n        (lcas_n),
  .ucas_n        (ucas_n),
  .pause_active  (pause_active),
  .interval_tick (interval_tick)
);

// File: tb/dram_housekeeper_test.sv
`timescale 1ns/1ps
module dram_housekeeper_test;
  // expected timing at 125 MHz, restated in whole-MHz arithmetic
  function automatic int up_cyc(int ns);
    return (ns * 125 + 999) / 1000;
  endfunction
  function automatic int refresh_gap(int window_us, int rows);
    return (window_us * 125) / rows;
  endfunction

  localparam int PAUSE = up_cyc(200_000);
  localparam int TRAS  = up_cyc(50);
  localparam int TRP   = up_cyc(30);
  localparam int CSR   = up_cyc(10);
  localparam int N     = refresh_gap(64_000, 4096);
  localparam int PMAX  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic init_done, ref_req, ref_urgent, strobe_own;
  logic ras_n, lcas_n, ucas_n, we_n, oe_n;

  always #4 clk = ~clk;

  dram_housekeeper uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt),
    .init_done(init_done), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .strobe_own(strobe_own), .ras_n(ras_n), .lcas_n(lcas_n),
    .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // strobe monitor
  int  cyc, ras_falls, first_fall, lo_run, hi_run, cas_run;
  int  cas_bad, weoe_bad, own_bad;
  bit  prev_ras, prev_cas, have_rise;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; ras_falls = 0; first_fall = -1; lo_run = 0; hi_run = 0;
      cas_run = 0; cas_bad = 0; weoe_bad = 0; own_bad = 0;
      prev_ras = 1; prev_cas = 1; have_rise = 0;
    end else begin
      cyc++;
      cas_run = (!lcas_n && !ucas_n) ? cas_run + 1 : 0;
      if (prev_ras && !ras_n) begin
        ras_falls++;
        if (first_fall < 0) first_fall = cyc;
        chk(cas_run >= CSR + 1, "R4 cas setup before ras", cas_run - 1, CSR);
        if (init_done) chk(ref_gnt, "R9 ras fall without grant", ref_gnt, 1);
      end
      if (!prev_ras && ras_n) begin
        chk(lo_run == TRAS, "R5 ras low width", lo_run, TRAS);
        have_rise = 1;
      end
      if (prev_cas && !lcas_n && have_rise)
        chk(hi_run >= TRP, "R6 precharge gap", hi_run, TRP);
      lo_run = ras_n ? 0 : lo_run + 1;
      hi_run = ras_n ? hi_run + 1 : 0;
      if (!ras_n && (lcas_n || ucas_n)) cas_bad++;
      if (!we_n || !oe_n) weoe_bad++;
      if ((!ras_n || !lcas_n || !ucas_n) && !strobe_own) own_bad++;
      prev_ras = ras_n;
      prev_cas = lcas_n;
    end
  end

  task automatic grant_round(input int m, input string tag);
    int r, d, expn, f0, guard;
    expn = (m + 1 > PMAX) ? PMAX : m + 1;
    r = N / 4 + int'($urandom % (N / 2));
    d = m * N + r;
    f0 = ras_falls;
    repeat (d) @(negedge clk);
    chk(ras_falls == f0, "R9 no refresh while not granted", ras_falls - f0, 0);
    chk(ref_req == 1'b1, "R8 request held while owed", ref_req, 1);
    chk(ref_urgent == (expn == PMAX), "R11 urgent flag", ref_urgent, expn == PMAX);
    ref_gnt = 1'b1;
    f0 = ras_falls;
    guard = 0;
    while (ref_req && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    ref_gnt = 1'b0;
    chk(ras_falls - f0 == expn, tag, ras_falls - f0, expn);
    chk(ref_urgent == 1'b0, "R11 urgent cleared after burst", ref_urgent, 0);
  endtask

  task automatic wait_req();
    int guard = 0;
    while (!ref_req && guard < 2 * N) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    int lat;
    void'($urandom(32'd7));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(ras_n && lcas_n && ucas_n, "R1 strobes high in reset", {ras_n, lcas_n, ucas_n}, 7);
    chk(we_n && oe_n, "R1 we/oe high in reset", {we_n, oe_n}, 3);
    chk(!init_done && !ref_req && !ref_urgent && !strobe_own, "R1 flags low in reset",
        {init_done, ref_req, ref_urgent, strobe_own}, 0);
    rst_n = 1'b1;

    while (!init_done) @(negedge clk);
    chk(first_fall >= PAUSE, "R2 pause before first ras", first_fall, PAUSE);
    chk(ras_falls == 8, "R3 init ras pulses", ras_falls, 8);

    lat = 0;
    while (!ref_req && lat < 3 * N) begin
      @(negedge clk);
      lat++;
      chk(init_done, "R3 init_done stays high", init_done, 1);
    end
    chk(lat == N, "R8 first request latency", lat, N);

    grant_round(0, "R10 single refresh burst");
    for (int i = 0; i < 3; i++) begin
      wait_req();
      grant_round(int'($urandom % 6), "R10 random backlog burst");
    end
    wait_req();
    grant_round(6, "R10 seven owed refreshes");
    wait_req();
    grant_round(7, "R10 full backlog burst");
    wait_req();
    grant_round(10, "R12 saturated backlog burst");

    chk(cas_bad == 0, "R4 cas low throughout ras low", cas_bad, 0);
    chk(weoe_bad == 0, "R7 we/oe held high", weoe_bad, 0);
    chk(own_bad == 0, "R13 strobe_own covers strobes", own_bad, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190_000, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule